// File: doc/BRIEF.md
# Digital Potentiometer Wiper and Shutdown Controller

This block keeps the digital state of a one- or two-channel variable resistor: one wiper code register per channel and two latched general-purpose logic outputs. A serial front end decodes bus frames and hands the results to this block as single-cycle strobes. An instruction strobe carries a channel select bit, a midscale-reset bit, a software-shutdown bit and the two logic output levels. A data strobe carries a new wiper code for the channel most recently selected.

For every channel the block drives the tap code the resistor ladder should use and two switch enables. One enable opens terminal A and the other ties the wiper to terminal B. A channel is shut down when its own software-shutdown flag is set or when the active-low shutdown pin is held low. The pin is asynchronous to the clock and passes through a two-flop synchroniser. Shutdown never alters a stored code, so the stored code returns to the tap when shutdown ends.

Top module: `dpot_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every stored code and tap code becomes 0x80, both logic outputs become 0 and no channel is shut down.
- R2: A `data_stb` without an `instr_stb` in the same cycle writes `data_code` into the channel chosen by the last instruction (select 0 is channel 1 at tap bits [7:0], select 1 is channel 2 at bits [15:8]). The new code shows on the tap after that clock edge, and codes 0x00 and 0xFF are stored unchanged.
- R3: An instruction with the midscale bit set writes 0x80 into the selected channel on that edge. The other channel keeps its code.
- R4: An instruction with the software-shutdown bit set shuts down only the selected channel on that edge: its A-open and wiper-to-B enables both go to 1 and its tap code reads 0x00. The other channel is not affected.
- R5: A shutdown keeps the stored code. The next instruction to the same channel with the shutdown bit clear ends the shutdown on that edge, and the tap again shows the stored code.
- R6: After `shdn_n` goes low, every channel is shut down from the second rising clock edge on, and not at the first. After `shdn_n` returns high, the stored codes reappear from the second rising edge. No stored code changes.
- R7: Every instruction loads its two logic-output bits into `lout1`/`lout2` on that edge. Without an instruction the outputs hold. Loading them leaves the wiper codes as they are.
- R8: When `instr_stb` and `data_stb` share a cycle, the data goes to the channel selected by that same instruction. If that instruction also has the midscale bit set, 0x80 is stored and the data is dropped.
- R9: A data strobe to a shut-down channel still updates its stored code while the tap stays at 0x00. The new code appears once the shutdown ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_n | input | 1 | Asynchronous active-low shutdown pin for all channels |
| instr_stb | input | 1 | One-cycle strobe: instruction fields valid |
| instr_sel | input | 1 | Channel select (0 = channel 1, 1 = channel 2) |
| instr_midrst | input | 1 | Midscale reset of the selected channel |
| instr_swsd | input | 1 | Software shutdown of the selected channel |
| instr_o1 | input | 1 | New level for logic output 1 |
| instr_o2 | input | 1 | New level for logic output 2 |
| data_stb | input | 1 | One-cycle strobe: wiper code valid |
| data_code | input | CODE_W | Wiper code to store |
| tap_code | output | NUM_CH*CODE_W | Effective tap per channel (0 when shut down) |
| a_open | output | NUM_CH | Per channel: open terminal A |
| w_to_b | output | NUM_CH | Per channel: tie wiper to terminal B |
| lout1 | output | 1 | Latched logic output 1 |
| lout2 | output | 1 | Latched logic output 2 |
| store_code | output | NUM_CH*CODE_W | Stored wiper codes, unaffected by shutdown |

## Verification
Two operations can act on one register in the same cycle: an instruction that selects a channel and asks for a midscale reset, and a data strobe that loads a code. The bench raises both strobes on one edge, once with the midscale bit clear and once with it set. It expects the data code on the newly selected channel in the first case and 0x80 in the second. It also loads a code into a channel held in software shutdown and into channels held down by the pin, and checks that the tap stays at zero and that the stored code shows once the shutdown ends.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    // Decoded instruction fields handed over by the serial front end
    typedef struct packed {
        logic sel;
        logic mid_rst;
        logic sw_shdn;
        logic o1;
        logic o2;
    } dpot_instr_t;

    // Midscale value for a code of the given width
    function automatic logic [31:0] mid_code(input int width);
        return 32'd1 << (width - 1);
    endfunction

endpackage

// File: rtl/dpot_shdn_sync.sv
module dpot_shdn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic shut
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], pin_n};
    end

    assign shut = ~chain[STAGES-1];
endmodule

// File: rtl/dpot_chan.sv
module dpot_chan #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_instr,
    input  logic              mid_rst,
    input  logic              sw_shdn,
    input  logic              wr_data,
    input  logic [CODE_W-1:0] data,
    input  logic              pin_shut,
    output logic [CODE_W-1:0] stored,
    output logic [CODE_W-1:0] tap,
    output logic              a_open,
    output logic              w_to_b
);
    import dpot_pkg::*;

    localparam logic [CODE_W-1:0] MID = CODE_W'(mid_code(CODE_W));

    logic [CODE_W-1:0] code_q;
    logic              sd_q;
    logic              shut;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= MID;
            sd_q   <= 1'b0;
        end else begin
            if (wr_instr && mid_rst) code_q <= MID;
            else if (wr_data)        code_q <= data;
            if (wr_instr)            sd_q   <= sw_shdn;
        end
    end

    assign shut   = sd_q | pin_shut;
    assign stored = code_q;
    assign tap    = shut ? '0 : code_q;
    assign a_open = shut;
    assign w_to_b = shut;
endmodule

// File: rtl/dpot_lout.sv
module dpot_lout (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  dpot_pkg::dpot_instr_t ins,
    output logic                  lout1,
    output logic                  lout2
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lout1 <= 1'b0;
            lout2 <= 1'b0;
        end else if (load) begin
            lout1 <= ins.o1;
            lout2 <= ins.o2;
        end
    end
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl #(
    parameter int NUM_CH      = 2,
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     shdn_n,
    input  logic                     instr_stb,
    input  logic                     instr_sel,
    input  logic                     instr_midrst,
    input  logic                     instr_swsd,
    input  logic                     instr_o1,
    input  logic                     instr_o2,
    input  logic                     data_stb,
    input  logic [CODE_W-1:0]        data_code,
    output logic [NUM_CH*CODE_W-1:0] tap_code,
    output logic [NUM_CH-1:0]        a_open,
    output logic [NUM_CH-1:0]        w_to_b,
    output logic                     lout1,
    output logic                     lout2,
    output logic [NUM_CH*CODE_W-1:0] store_code
);
    import dpot_pkg::*;

    dpot_instr_t ins;
    logic        new_sel;
    logic        cur_sel;
    logic        tgt_sel;
    logic        pin_shut;

    // A single-channel build always addresses channel 1
    generate
        if (NUM_CH > 1) begin : g_sel_dual
            assign new_sel = instr_sel;
        end else begin : g_sel_single
            logic unused_sel;
            assign unused_sel = instr_sel;
            assign new_sel    = 1'b0;
        end
    endgenerate

    assign ins = '{sel: new_sel, mid_rst: instr_midrst, sw_shdn: instr_swsd,
                   o1: instr_o1, o2: instr_o2};

    always_ff @(posedge clk) begin
        if (rst)            cur_sel <= 1'b0;
        else if (instr_stb) cur_sel <= ins.sel;
    end

    assign tgt_sel = instr_stb ? ins.sel : cur_sel;

    dpot_shdn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_n (shdn_n),
        .shut  (pin_shut)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic hit;
            assign hit = (tgt_sel == 1'(c));
            dpot_chan #(.CODE_W(CODE_W)) u_chan (
                .clk      (clk),
                .rst      (rst),
                .wr_instr (instr_stb && hit),
                .mid_rst  (ins.mid_rst),
                .sw_shdn  (ins.sw_shdn),
                .wr_data  (data_stb && hit),
                .data     (data_code),
                .pin_shut (pin_shut),
                .stored   (store_code[c*CODE_W +: CODE_W]),
                .tap      (tap_code[c*CODE_W +: CODE_W]),
                .a_open   (a_open[c]),
                .w_to_b   (w_to_b[c])
            );
        end
    endgenerate

    dpot_lout u_lout (
        .clk   (clk),
        .rst   (rst),
        .load  (instr_stb),
        .ins   (ins),
        .lout1 (lout1),
        .lout2 (lout2)
    );
endmodule

// File: rtl/dpot_ctrl_chk.sv
module dpot_ctrl_chk #(
    parameter int NUM_CH = 2,
    parameter int CODE_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     instr_stb,
    input logic                     instr_sel,
    input logic                     instr_midrst,
    input logic                     instr_swsd,
    input logic                     instr_o1,
    input logic                     instr_o2,
    input logic                     data_stb,
    input logic [CODE_W-1:0]        data_code,
    input logic [NUM_CH*CODE_W-1:0] tap_code,
    input logic [NUM_CH-1:0]        a_open,
    input logic [NUM_CH-1:0]        w_to_b,
    input logic                     lout1,
    input logic                     lout2,
    input logic [NUM_CH*CODE_W-1:0] store_code,
    input logic                     cur_sel,
    input logic                     pin_shut
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(dpot_pkg::mid_code(CODE_W));

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (tap_code == {NUM_CH{MID}}) && !lout1 && !lout2 && (a_open == '0)); // R1

    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (rst)
        data_stb && !instr_stb && !cur_sel |=> store_code[CODE_W-1:0] == $past(data_code)); // R2

    AST_MID_RESET: assert property (@(posedge clk) disable iff (rst)
        instr_stb && instr_midrst && !instr_sel |=> store_code[CODE_W-1:0] == MID); // R3

    AST_SW_SHUT: assert property (@(posedge clk) disable iff (rst)
        instr_stb && instr_swsd && !instr_sel |=> a_open[0] && w_to_b[0]); // R4

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !instr_stb && !data_stb |=> $stable(store_code)); // R5

    AST_PIN_SHUT: assert property (@(posedge clk) disable iff (rst)
        pin_shut |-> (&a_open) && (&w_to_b)); // R6

    AST_LOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
        instr_stb |=> lout1 == $past(instr_o1) && lout2 == $past(instr_o2)); // R7

    AST_LOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !instr_stb |=> $stable(lout1) && $stable(lout2)); // R7
endmodule

bind dpot_ctrl dpot_ctrl_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/dpot_ctrl_bench.sv
`timescale 1ns/1ps
module dpot_ctrl_bench;
    localparam int NUM_CH = 2;
    localparam int CODE_W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        shdn_n = 1'b1;
    logic        instr_stb = 1'b0, instr_sel = 1'b0, instr_midrst = 1'b0;
    logic        instr_swsd = 1'b0, instr_o1 = 1'b0, instr_o2 = 1'b0;
    logic        data_stb = 1'b0;
    logic [7:0]  data_code = 8'h00;
    logic [15:0] tap_code, store_code;
    logic [1:0]  a_open, w_to_b;
    logic        lout1, lout2;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dpot_ctrl #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dpot_ctrl (
        .clk(clk), .rst(rst), .shdn_n(shdn_n),
        .instr_stb(instr_stb), .instr_sel(instr_sel), .instr_midrst(instr_midrst),
        .instr_swsd(instr_swsd), .instr_o1(instr_o1), .instr_o2(instr_o2),
        .data_stb(data_stb), .data_code(data_code),
        .tap_code(tap_code), .a_open(a_open), .w_to_b(w_to_b),
        .lout1(lout1), .lout2(lout2), .store_code(store_code)
    );

    typedef struct packed {
        logic        is;
        logic        sel;
        logic        mr;
        logic        sd;
        logic        o1;
        logic        o2;
        logic        ds;
        logic [7:0]  code;
        logic [15:0] etap;
        logic [1:0]  eao;
        logic        el1;
        logic        el2;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,8'h00, 16'h8080,2'b00,1'b1,1'b0, 8'd7}, // R7
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h3C, 16'h803C,2'b00,1'b1,1'b0, 8'd2}, // R2
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0,8'h00, 16'h803C,2'b00,1'b0,1'b1, 8'd7}, // R7
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'hF1, 16'hF13C,2'b00,1'b0,1'b1, 8'd2}, // R2
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0,8'h00, 16'h003C,2'b10,1'b0,1'b0, 8'd4}, // R4
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h22, 16'h003C,2'b10,1'b0,1'b0, 8'd9}, // R9
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00, 16'h223C,2'b00,1'b0,1'b0, 8'd5}, // R5
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,8'h00, 16'h2280,2'b00,1'b0,1'b0, 8'd3}, // R3
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h55, 16'h2255,2'b00,1'b0,1'b0, 8'd8}, // R8
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,8'h99, 16'h8055,2'b00,1'b0,1'b0, 8'd8}, // R8
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 1'b0,8'h00, 16'h8000,2'b01,1'b1,1'b1, 8'd4}, // R4
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00, 16'h8055,2'b00,1'b0,1'b0, 8'd5}, // R5
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h00, 16'h8000,2'b00,1'b0,1'b0, 8'd2}, // R2
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'hFF, 16'h80FF,2'b00,1'b0,1'b0, 8'd2}  // R2
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_outs(input string req, input logic [15:0] etap,
                              input logic [1:0] eao, input logic el1, input logic el2);
        check(req, "tap_code", 32'(tap_code), 32'(etap));
        check(req, "a_open",   32'(a_open),   32'(eao));
        check(req, "w_to_b",   32'(w_to_b),   32'(eao));
        check(req, "lout",     {30'd0, lout1, lout2}, {30'd0, el1, el2});
    endtask

    // Drive one cycle of strobes, then look at the outputs after that edge
    task automatic step(input vec_t v);
        @(negedge clk);
        instr_stb = v.is; instr_sel = v.sel; instr_midrst = v.mr; instr_swsd = v.sd;
        instr_o1 = v.o1;  instr_o2 = v.o2;   data_stb = v.ds;    data_code = v.code;
        @(negedge clk);
        instr_stb = 1'b0; data_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_outs("R1", 16'h8080, 2'b00, 1'b0, 1'b0);   // reset state

        for (int i = 0; i < NV; i++) begin
            step(VEC[i]);
            check_outs($sformatf("R%0d", VEC[i].req), VEC[i].etap, VEC[i].eao,
                       VEC[i].el1, VEC[i].el2);
        end

        // R6: pin shutdown takes two edges in, two edges out
        shdn_n = 1'b0;
        @(negedge clk);
        check_outs("R6", 16'h80FF, 2'b00, 1'b0, 1'b0);
        @(negedge clk);
        check_outs("R6", 16'h0000, 2'b11, 1'b0, 1'b0);
        // R9: load a code while the pin holds everything down
        step('{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h11, 16'h0000,2'b11,1'b0,1'b0, 8'd9});
        check_outs("R9", 16'h0000, 2'b11, 1'b0, 1'b0);
        check("R6", "store_code", 32'(store_code), 32'h8011);
        shdn_n = 1'b1;
        @(negedge clk);
        check_outs("R6", 16'h0000, 2'b11, 1'b0, 1'b0);
        @(negedge clk);
        check_outs("R6", 16'h8011, 2'b00, 1'b0, 1'b0);

        // R1: reset in mid-run restores midscale and clears the logic outputs
        step('{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1, 1'b1,8'h44, 16'h0011,2'b10,1'b1,1'b1, 8'd4});
        check_outs("R4", 16'h0011, 2'b10, 1'b1, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_outs("R1", 16'h8080, 2'b00, 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule